// File: doc/BRIEF.md
# DMA channel count-to-zero reload unit

This unit keeps the working source address, destination address and remaining transfer count for one DMA channel. It decides what happens when the remaining count runs out. The bus master reports each finished burst with a strobe and the number of units that burst moved. The unit then subtracts that number from the count. The terminal test is made only on those strobes, never per beat.

When a finished burst leaves the count at zero there are two outcomes. If software has armed a reload, all three working values are replaced at once from shadow registers and the channel keeps running. If no reload is armed, the channel shuts itself off. The reload uses the channel configuration that is already programmed, so software can chain buffers without touching the channel setup. Sticky status flags and an interrupt request report the count-to-zero event, bus errors and time-outs.

Top module: `dma_ctz_reload`

## Requirements
- R1: After synchronous reset every output is zero: addresses, count, channel enable, all status bits and the interrupt request.
- R2: A burst-done strobe while the channel is disabled changes nothing: count, addresses, enable and the count-to-zero flag all keep their values.
- R3: A burst-done strobe on an enabled channel lowers the count by the burst's unit number. If that number is greater than or equal to the remaining count, the result is zero and never wraps.
- R4: When an accepted burst leaves the count at zero and reload is armed, source, destination and count all take the reload register values in the same clock. The channel stays enabled and the interrupt-enable settings are unchanged.
- R5: When an accepted burst leaves the count at zero and reload is not armed, the channel enable and status bit 0 drop to 0.
- R6: The reload arm flag clears itself when a reload consumes it. A further zero count with no new arm stops the channel.
- R7: The count-to-zero flag is sticky. Writing the status select with data bit 2 = 1 clears it, and writing 0 there has no effect. A new event in the same cycle wins over a clear.
- R8: Status bits are: [0] channel enabled, [1] pending, [2] count-to-zero, [3] reload armed, [4] bus error, [5] time-out. The bus-error and time-out event inputs set the sticky bits 4 and 5, which data bits 4 and 5 clear on a status write.
- R9: Pending is (bit2 AND count-to-zero enable) OR ((bit4 OR bit5) AND status-event enable). The interrupt output is pending AND the channel interrupt enable.
- R10: The register select codes are: 0 source, 1 destination, 2 count, 3 reload source, 4 reload destination, 5 reload count (data bit 31 arms the reload), 6 control, 7 status clear. Control data bits are: [0] enable, [1] count-to-zero interrupt enable, [2] status-event interrupt enable, [3] channel interrupt enable.
- R11: A count that is zero, or that a burst leaves nonzero, raises no count-to-zero event until an accepted burst finishes with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | DATA_W | Write data |
| burst_done | input | 1 | A channel burst has finished |
| burst_units | input | CNT_W | Units moved by the finished burst |
| bus_err_evt | input | 1 | Bus error event for the channel |
| timeout_evt | input | 1 | Request idle time-out event |
| cur_src | output | ADDR_W | Working source address |
| cur_dst | output | ADDR_W | Working destination address |
| cur_cnt | output | CNT_W | Remaining count |
| chan_en | output | 1 | Channel enabled |
| chan_status | output | 6 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the chained zero: the count must reach zero on a burst that arrives while a reload is armed. A second zero must then arrive after the arm flag has been spent. The stimulus programs a small count and both reload addresses, arms a reload, and then sends an oversized burst so the saturating path and the reload happen in the same cycle. Without re-arming, it then drains the reloaded count exactly. This shows that the channel stops the second time and keeps the configuration it had.

// File: rtl/dma_ctz_pkg.sv
package dma_ctz_pkg;
  typedef enum logic [2:0] {
    SEL_SRC  = 3'd0,
    SEL_DST  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_RSRC = 3'd3,
    SEL_RDST = 3'd4,
    SEL_RCNT = 3'd5,
    SEL_CTRL = 3'd6,
    SEL_STAT = 3'd7
  } reg_sel_e;

  localparam int ST_EN   = 0;
  localparam int ST_PEND = 1;
  localparam int ST_CTZ  = 2;
  localparam int ST_ARM  = 3;
  localparam int ST_BERR = 4;
  localparam int ST_TMO  = 5;
  localparam int ST_W    = 6;
endpackage

// File: rtl/dma_ctz_decr.sv
module dma_ctz_decr #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [CNT_W-1:0] units,
  output logic [CNT_W-1:0] cnt_out,
  output logic             at_zero
);
  logic exhausted;

  always_comb begin
    exhausted = (units >= cnt_in);
    cnt_out   = exhausted ? '0 : (cnt_in - units);
    at_zero   = exhausted;
  end
endmodule

// File: rtl/dma_ctz_shadow.sv
module dma_ctz_shadow
  import dma_ctz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              consume,
  output logic [ADDR_W-1:0] rld_src,
  output logic [ADDR_W-1:0] rld_dst,
  output logic [CNT_W-1:0]  rld_cnt,
  output logic              armed
);
  localparam int ARM_BIT = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_src <= '0;
      rld_dst <= '0;
      rld_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_RSRC) rld_src <= wr_data[ADDR_W-1:0];
      if (wr_en && sel == SEL_RDST) rld_dst <= wr_data[ADDR_W-1:0];
      if (wr_en && sel == SEL_RCNT) begin
        rld_cnt <= wr_data[CNT_W-1:0];
        armed   <= wr_data[ARM_BIT];
      end else if (consume) begin
        armed   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_ctz_status.sv
module dma_ctz_status
  import dma_ctz_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_sel_e        sel,
  input  logic [ST_W-1:1] wr_bits,
  input  logic            ctz_evt,
  input  logic            berr_evt,
  input  logic            tmo_evt,
  input  logic            chan_en,
  input  logic            armed,
  output logic [ST_W-1:0] chan_status,
  output logic            irq
);
  logic ien_ctz, ien_sta, ien_chan;
  logic f_ctz, f_berr, f_tmo;
  logic clr, pend;

  assign clr = wr_en && (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_ctz  <= 1'b0;
      ien_sta  <= 1'b0;
      ien_chan <= 1'b0;
      f_ctz    <= 1'b0;
      f_berr   <= 1'b0;
      f_tmo    <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) begin
        ien_ctz  <= wr_bits[1];
        ien_sta  <= wr_bits[2];
        ien_chan <= wr_bits[3];
      end
      f_ctz  <= (f_ctz  & ~(clr & wr_bits[ST_CTZ]))  | ctz_evt;
      f_berr <= (f_berr & ~(clr & wr_bits[ST_BERR])) | berr_evt;
      f_tmo  <= (f_tmo  & ~(clr & wr_bits[ST_TMO]))  | tmo_evt;
    end
  end

  always_comb begin
    pend                 = (f_ctz & ien_ctz) | ((f_berr | f_tmo) & ien_sta);
    chan_status          = '0;
    chan_status[ST_EN]   = chan_en;
    chan_status[ST_PEND] = pend;
    chan_status[ST_CTZ]  = f_ctz;
    chan_status[ST_ARM]  = armed;
    chan_status[ST_BERR] = f_berr;
    chan_status[ST_TMO]  = f_tmo;
    irq                  = pend & ien_chan;
  end
endmodule

// File: rtl/dma_ctz_reload.sv
module dma_ctz_reload
  import dma_ctz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              burst_done,
  input  logic [CNT_W-1:0]  burst_units,
  input  logic              bus_err_evt,
  input  logic              timeout_evt,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              chan_en,
  output logic [ST_W-1:0]   chan_status,
  output logic              irq
);
  reg_sel_e          sel;
  logic              accept, at_zero, ctz_evt, do_reload, do_stop, armed;
  logic [CNT_W-1:0]  rem_cnt, rld_cnt;
  logic [ADDR_W-1:0] rld_src, rld_dst;

  assign sel       = reg_sel_e'(wr_sel);
  assign accept    = burst_done & chan_en;
  assign ctz_evt   = accept & at_zero;
  assign do_reload = ctz_evt & armed;
  assign do_stop   = ctz_evt & ~armed;

  dma_ctz_decr #(.CNT_W(CNT_W)) u_decr (
    .cnt_in (cur_cnt),
    .units  (burst_units),
    .cnt_out(rem_cnt),
    .at_zero(at_zero)
  );

  dma_ctz_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .sel    (sel),
    .wr_data(wr_data),
    .consume(do_reload),
    .rld_src(rld_src),
    .rld_dst(rld_dst),
    .rld_cnt(rld_cnt),
    .armed  (armed)
  );

  dma_ctz_status u_status (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .sel        (sel),
    .wr_bits    (wr_data[ST_W-1:1]),
    .ctz_evt    (ctz_evt),
    .berr_evt   (bus_err_evt),
    .tmo_evt    (timeout_evt),
    .chan_en    (chan_en),
    .armed      (armed),
    .chan_status(chan_status),
    .irq        (irq)
  );

  // Working registers: an accepted burst takes priority over a software write.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
    end else if (accept) begin
      if (do_reload) begin
        cur_src <= rld_src;
        cur_dst <= rld_dst;
        cur_cnt <= rld_cnt;
      end else begin
        cur_cnt <= rem_cnt;
      end
    end else if (wr_en) begin
      case (sel)
        SEL_SRC: cur_src <= wr_data[ADDR_W-1:0];
        SEL_DST: cur_dst <= wr_data[ADDR_W-1:0];
        SEL_CNT: cur_cnt <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            chan_en <= 1'b0;
    else if (do_stop)                   chan_en <= 1'b0;
    else if (wr_en && sel == SEL_CTRL)  chan_en <= wr_data[0];
  end
endmodule

// File: rtl/dma_ctz_reload_chk.sv
module dma_ctz_reload_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              burst_done,
  input logic [CNT_W-1:0]  burst_units,
  input logic [ADDR_W-1:0] cur_src,
  input logic [ADDR_W-1:0] cur_dst,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic              chan_en,
  input logic [3:0]        st_low,
  input logic [ADDR_W-1:0] rld_src,
  input logic [ADDR_W-1:0] rld_dst,
  input logic [CNT_W-1:0]  rld_cnt,
  input logic              irq
);
  a_r2_idle_burst: assert property (@(posedge clk) disable iff (rst)
    (!chan_en && burst_done && !wr_en) |=>
      ($stable(cur_cnt) && $stable(cur_src) && $stable(cur_dst) && !chan_en));

  a_r3_partial_step: assert property (@(posedge clk) disable iff (rst)
    (chan_en && burst_done && !wr_en && burst_units < cur_cnt) |=>
      (cur_cnt == $past(cur_cnt) - $past(burst_units) && chan_en));

  a_r4_chain_load: assert property (@(posedge clk) disable iff (rst)
    (chan_en && burst_done && !wr_en && burst_units >= cur_cnt && st_low[3]) |=>
      (chan_en && cur_cnt == $past(rld_cnt) && cur_src == $past(rld_src)
       && cur_dst == $past(rld_dst)));

  a_r5_halt: assert property (@(posedge clk) disable iff (rst)
    (chan_en && burst_done && !wr_en && burst_units >= cur_cnt && !st_low[3]) |=>
      (!chan_en && !st_low[0] && st_low[2]));

  a_r6_arm_spent: assert property (@(posedge clk) disable iff (rst)
    (chan_en && burst_done && !wr_en && burst_units >= cur_cnt && st_low[3]) |=>
      !st_low[3]);

  a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_low[1]);
endmodule

bind dma_ctz_reload dma_ctz_reload_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .burst_done (burst_done),
  .burst_units(burst_units),
  .cur_src    (cur_src),
  .cur_dst    (cur_dst),
  .cur_cnt    (cur_cnt),
  .chan_en    (chan_en),
  .st_low     (chan_status[3:0]),
  .rld_src    (rld_src),
  .rld_dst    (rld_dst),
  .rld_cnt    (rld_cnt),
  .irq        (irq)
);

// File: tb/dma_ctz_reload_bench.sv
module dma_ctz_reload_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        burst_done = 1'b0;
  logic [15:0] burst_units = '0;
  logic        bus_err_evt = 1'b0;
  logic        timeout_evt = 1'b0;
  logic [31:0] cur_src, cur_dst;
  logic [15:0] cur_cnt;
  logic        chan_en, irq;
  logic [5:0]  chan_status;

  always #4 clk = ~clk;

  dma_ctz_reload u_dma_ctz_reload (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .burst_done(burst_done), .burst_units(burst_units),
    .bus_err_evt(bus_err_evt), .timeout_evt(timeout_evt),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .chan_en(chan_en), .chan_status(chan_status), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic        en;
    logic [5:0]  st;
    logic        irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  logic [31:0] m_src = '0, m_dst = '0, m_rsrc = '0, m_rdst = '0;
  logic [15:0] m_cnt = '0, m_rcnt = '0;
  logic m_en = 0, m_arm = 0, m_ctz = 0, m_berr = 0, m_tmo = 0;
  logic m_cien = 0, m_sien = 0, m_gien = 0;

  task automatic op(input logic wen, input logic [2:0] sel, input logic [31:0] d,
                    input logic bd, input logic [15:0] u, input logic be,
                    input logic te, input string tag);
    logic acc, zero, arm_old, clr, pend;
    logic [15:0] rem;
    exp_t e;
    @(negedge clk);
    wr_en = wen; wr_sel = sel; wr_data = d; burst_done = bd;
    burst_units = u; bus_err_evt = be; timeout_evt = te;
    arm_old = m_arm;
    acc  = bd && m_en;
    rem  = (u >= m_cnt) ? 16'd0 : m_cnt - u;
    zero = acc && (rem == 16'd0);
    clr  = wen && sel == 3'd7;
    if (acc) begin
      if (zero && arm_old) begin m_src = m_rsrc; m_dst = m_rdst; m_cnt = m_rcnt; end
      else m_cnt = rem;
    end else if (wen) begin
      if (sel == 3'd0) m_src = d;
      if (sel == 3'd1) m_dst = d;
      if (sel == 3'd2) m_cnt = d[15:0];
    end
    if (zero && !arm_old) m_en = 1'b0;
    else if (wen && sel == 3'd6) m_en = d[0];
    if (wen && sel == 3'd6) begin m_cien = d[1]; m_sien = d[2]; m_gien = d[3]; end
    if (wen && sel == 3'd3) m_rsrc = d;
    if (wen && sel == 3'd4) m_rdst = d;
    if (wen && sel == 3'd5) begin m_rcnt = d[15:0]; m_arm = d[31]; end
    else if (zero && arm_old) m_arm = 1'b0;
    m_ctz  = (m_ctz  & ~(clr & d[2])) | zero;
    m_berr = (m_berr & ~(clr & d[4])) | be;
    m_tmo  = (m_tmo  & ~(clr & d[5])) | te;
    pend = (m_ctz & m_cien) | ((m_berr | m_tmo) & m_sien);
    e.src = m_src; e.dst = m_dst; e.cnt = m_cnt; e.en = m_en;
    e.st  = {m_tmo, m_berr, m_arm, m_ctz, pend, m_en};
    e.irq = pend & m_gien;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    wr_en = 0; burst_done = 0; bus_err_evt = 0; timeout_evt = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
    op(1'b1, sel, d, 1'b0, 16'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic burst(input logic [15:0] u, input string tag);
    op(1'b0, 3'd0, 32'd0, 1'b1, u, 1'b0, 1'b0, tag);
  endtask

  task automatic nop(input string tag);
    op(1'b0, 3'd0, 32'd0, 1'b0, 16'd0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: pops expected items and compares once outputs have settled.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        string t;
        exp_t a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.src = cur_src; a.dst = cur_dst; a.cnt = cur_cnt; a.en = chan_en;
        a.st = chan_status; a.irq = irq;
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual src=%h dst=%h cnt=%0d en=%b st=%b irq=%b expected src=%h dst=%h cnt=%0d en=%b st=%b irq=%b",
                   t, a.src, a.dst, a.cnt, a.en, a.st, a.irq,
                   e.src, e.dst, e.cnt, e.en, e.st, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    nop("R1 reset state");
    wr(3'd2, 32'd10, "R10 count write");
    wr(3'd0, 32'h0000_1000, "R10 source write");
    wr(3'd1, 32'h0000_2000, "R10 destination write");
    burst(16'd4, "R2 burst while disabled");
    wr(3'd6, 32'hF, "R10 control enable");
    burst(16'd3, "R3 partial decrement");
    burst(16'd5, "R11 nonzero remainder");
    wr(3'd3, 32'h0000_3000, "R10 reload source");
    wr(3'd4, 32'h0000_4000, "R10 reload destination");
    wr(3'd5, 32'h8000_0014, "R8 arm bit visible");
    burst(16'd9, "R4 R3 saturating zero with reload");
    nop("R6 arm spent, channel running");
    wr(3'd7, 32'h0, "R7 write zero keeps flag");
    wr(3'd7, 32'h4, "R7 write one clears flag");
    burst(16'd20, "R5 zero without reload stops");
    burst(16'd7, "R2 burst after stop ignored");
    wr(3'd6, 32'h6, "R9 channel enable gates irq");
    wr(3'd7, 32'h4, "R9 clear ctz drops pending");
    op(1'b0, 3'd0, 32'd0, 1'b0, 16'd0, 1'b1, 1'b0, "R8 bus error sticky");
    wr(3'd6, 32'hC, "R9 status event with channel irq");
    op(1'b0, 3'd0, 32'd0, 1'b0, 16'd0, 1'b0, 1'b1, "R8 timeout sticky");
    wr(3'd7, 32'h30, "R8 clear error and timeout");
    op(1'b1, 3'd7, 32'h10, 1'b0, 16'd0, 1'b1, 1'b0, "R7 event wins over clear");
    wr(3'd7, 32'h10, "R8 clear bus error");
    wr(3'd2, 32'd0, "R11 zero count written");
    wr(3'd6, 32'h3, "R11 enable with zero count");
    nop("R11 no event without burst");
    burst(16'd0, "R11 empty burst on zero count");
    wr(3'd2, 32'd6, "R10 count reload");
    wr(3'd3, 32'h0000_5000, "R10 second reload source");
    wr(3'd4, 32'h0000_6000, "R10 second reload destination");
    wr(3'd5, 32'h8000_0005, "R6 rearm");
    wr(3'd6, 32'hB, "R4 enable with config");
    burst(16'd6, "R4 exact drain reloads");
    burst(16'd2, "R3 step after reload");
    burst(16'd3, "R6 second zero stops without rearm");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule